// File: doc/BRIEF.md
# Synthesizer Divider Configuration Port

This block stores the settings a frequency synthesizer's divider chain runs from. Those settings are a 9-bit feedback divide value, a 2-bit post-divide code and a 3-bit test-select field. Two load paths feed them. The parallel path uses an active-low strobe: while the strobe is low, the divide inputs flow straight into the active settings, and its rising edge freezes them. The serial path uses a slow bit clock, a data line and a transfer strobe. Bits are pushed into a 14-bit shift register, and the falling edge of the transfer strobe copies the register into the active settings.

All control pins are asynchronous to the block's system clock. They pass through a shared synchronizer, so data and strobes keep their relative alignment. Edge detectors then turn the serial clock and the transfer strobe into one-cycle pulses. The serial path works only while the parallel strobe is high. While the parallel strobe is low, the test field is held at zero. The most significant shift-register bit is brought out so that a test multiplexer can observe the stream.

Top module: `synth_cfg_port`

## Requirements
- R1: After a synchronous active-low reset, the divide value, the post-divide code, the test field and the serial tap are all zero.
- R2: Each rising edge of the serial clock, while the parallel strobe is high, shifts the data bit into bit 0 of the 14-bit register and moves every bit up one place. The serial tap shows bit 13.
- R3: In the serial word, bits 13..11 hold the test field, bits 10..9 hold the post-divide code and bits 8..0 hold the divide value. Each field is sent most significant bit first, so the first bit sent ends up as the test field's top bit.
- R4: The active settings take the shift-register content on a falling edge of the transfer strobe. The rising edge of the transfer strobe changes nothing.
- R5: While the parallel strobe is low, the active divide value and post-divide code follow the parallel inputs.
- R6: A rising edge of the parallel strobe freezes the active settings. Later changes on the parallel inputs have no effect while the strobe stays high.
- R7: While the parallel strobe is low, the active test field is 000.
- R8: Serial clock edges that arrive while the parallel strobe is low do not shift the register.
- R9: A transfer-strobe falling edge that arrives while the parallel strobe is low does not load the shift-register content.
- R10: While the parallel strobe is high, the active settings change only on a transfer-strobe falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every control pin |
| rst_n | input | 1 | Synchronous active-low reset |
| pstrobe_i | input | 1 | Parallel strobe: low means transparent, rising edge freezes |
| par_m_i | input | 9 | Parallel divide value |
| par_n_i | input | 2 | Parallel post-divide code |
| ser_clk_i | input | 1 | Serial bit clock, sampled on its rising edge |
| ser_dat_i | input | 1 | Serial data line |
| ser_xfer_i | input | 1 | Transfer strobe, acts on its falling edge |
| m_o | output | 9 | Active divide value |
| n_o | output | 2 | Active post-divide code |
| t_o | output | 3 | Active test-select field |
| ser_tap_o | output | 1 | Most significant shift-register bit |

## Verification
The hardest cases to reach are the ones where a serial action arrives while the parallel strobe is low. Shift edges and transfer pulses must then leave the register and the settings as they were. This can only be seen later, when a transfer with the strobe high reveals the register still holds the earlier word. The stimulus first fills the register with a known random word, then drops the strobe and sends a different random stream and a transfer pulse. It then raises the strobe and transfers, and expects the earlier word. Random divide values, codes and serial words are mixed with directed strobe orderings throughout.

// File: rtl/synth_cfg_pkg.sv
// Package: field widths and the packed layout of the serial configuration word.
// Assumes the serial word order test field, then post-divide code, then divide value.
package synth_cfg_pkg;
    localparam int M_W  = 9;
    localparam int N_W  = 2;
    localparam int T_W  = 3;
    localparam int SR_W = T_W + N_W + M_W;

    typedef struct packed {
        logic [T_W-1:0] t;
        logic [N_W-1:0] n;
        logic [M_W-1:0] m;
    } cfg_t;
endpackage

// File: rtl/sync_bits.sv
// Multi-stage synchronizer for a vector of asynchronous pins.
// Assumes all bits share one depth, so bits that change together stay aligned.
module sync_bits #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] st [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // Purpose: one register stage of the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) st[g] <= '0;
                else if (g == 0) st[g] <= d_i;
                else st[g] <= st[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign q_o = st[STAGES-1];
endmodule

// File: rtl/edge_pulse.sv
// Turns a synchronized level into a one-cycle pulse on the chosen edge.
// Assumes the input is already synchronous; RISING=1 picks the rising edge, 0 the falling edge.
module edge_pulse #(
    parameter bit RISING = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic pulse_o
);
    logic prev_q;

    // Purpose: remember the level from the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl_i;
    end

    generate
        if (RISING) begin : g_rise
            assign pulse_o = lvl_i & ~prev_q;
        end else begin : g_fall
            assign pulse_o = ~lvl_i & prev_q;
        end
    endgenerate
endmodule

// File: rtl/cfg_shift.sv
// Serial shift register: bit 0 takes the new data, bit SR_W-1 is the oldest.
// Assumes the enable is a one-cycle pulse that is already gated by the parallel strobe.
module cfg_shift
    import synth_cfg_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_i,
    input  logic            dat_i,
    output logic [SR_W-1:0] sr_o
);
    // Purpose: shift one bit in per enable pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)    sr_o <= '0;
        else if (en_i) sr_o <= {sr_o[SR_W-2:0], dat_i};
    end
endmodule

// File: rtl/cfg_regs.sv
// Active setting registers: transparent to the parallel inputs while the strobe is low,
// loaded from the shift register on a transfer pulse while the strobe is high.
// Assumes every input is synchronous to clk.
module cfg_regs
    import synth_cfg_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pl_lvl_i,
    input  logic           xfer_i,
    input  logic [M_W-1:0] par_m_i,
    input  logic [N_W-1:0] par_n_i,
    input  cfg_t           sr_i,
    output cfg_t           act_o
);
    // Purpose: choose between parallel follow, serial transfer and hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_o <= '0;
        end else if (!pl_lvl_i) begin
            act_o.m <= par_m_i;
            act_o.n <= par_n_i;
            act_o.t <= '0;
        end else if (xfer_i) begin
            act_o <= sr_i;
        end
    end
endmodule

// File: rtl/synth_cfg_port.sv
// Top: configuration port for a synthesizer's divider settings.
// Assumes the strobes are wide enough to last several system clocks, and that data
// stays stable around them, so one synchronizer chain keeps data and strobes aligned.
module synth_cfg_port
    import synth_cfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pstrobe_i,
    input  logic [M_W-1:0] par_m_i,
    input  logic [N_W-1:0] par_n_i,
    input  logic           ser_clk_i,
    input  logic           ser_dat_i,
    input  logic           ser_xfer_i,
    output logic [M_W-1:0] m_o,
    output logic [N_W-1:0] n_o,
    output logic [T_W-1:0] t_o,
    output logic           ser_tap_o
);
    localparam int PIN_W = 4 + M_W + N_W;

    logic [PIN_W-1:0] pins_s;
    logic             pl_lvl, sclk_lvl, xfer_lvl, sdat_s;
    logic [M_W-1:0]   pm_s;
    logic [N_W-1:0]   pn_s;
    logic             sclk_rise, xfer_fall;
    logic [SR_W-1:0]  sr_q;
    cfg_t             act;

    sync_bits #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({pstrobe_i, ser_clk_i, ser_xfer_i, ser_dat_i, par_m_i, par_n_i}),
        .q_o   (pins_s)
    );

    assign {pl_lvl, sclk_lvl, xfer_lvl, sdat_s, pm_s, pn_s} = pins_s;

    edge_pulse #(.RISING(1'b1)) u_sclk_edge (
        .clk (clk), .rst_n (rst_n), .lvl_i (sclk_lvl), .pulse_o (sclk_rise)
    );

    edge_pulse #(.RISING(1'b0)) u_xfer_edge (
        .clk (clk), .rst_n (rst_n), .lvl_i (xfer_lvl), .pulse_o (xfer_fall)
    );

    cfg_shift u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (pl_lvl & sclk_rise),
        .dat_i (sdat_s),
        .sr_o  (sr_q)
    );

    cfg_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .pl_lvl_i (pl_lvl),
        .xfer_i   (xfer_fall),
        .par_m_i  (pm_s),
        .par_n_i  (pn_s),
        .sr_i     (cfg_t'(sr_q)),
        .act_o    (act)
    );

    assign m_o       = act.m;
    assign n_o       = act.n;
    assign t_o       = act.t;
    assign ser_tap_o = sr_q[SR_W-1];
endmodule

// File: rtl/synth_cfg_port_chk.sv
// Checker: temporal properties of the configuration port, bound into the top.
// Assumes the synchronized strobe level and edge pulses named in the top.
module synth_cfg_port_chk
    import synth_cfg_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            pl_lvl,
    input logic            sclk_rise,
    input logic            xfer_fall,
    input logic [SR_W-1:0] sr_q,
    input logic [M_W-1:0]  m_o,
    input logic [N_W-1:0]  n_o,
    input logic [T_W-1:0]  t_o,
    input logic            ser_tap_o
);
    a_r1_reset_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (m_o == '0 && n_o == '0 && t_o == '0 && !ser_tap_o));

    a_r2_shift_step: assert property (@(posedge clk) disable iff (!rst_n)
        (pl_lvl && sclk_rise) |=> (ser_tap_o == $past(sr_q[SR_W-2])));

    a_r4_xfer_load: assert property (@(posedge clk) disable iff (!rst_n)
        (pl_lvl && xfer_fall) |=> ({t_o, n_o, m_o} == $past(sr_q)));

    a_r7_test_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !pl_lvl |=> (t_o == '0));

    a_r8_no_shift: assert property (@(posedge clk) disable iff (!rst_n)
        !pl_lvl |=> $stable(sr_q));

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pl_lvl && !xfer_fall && $past(pl_lvl)) |=> ($stable(m_o) && $stable(n_o) && $stable(t_o)));
endmodule

bind synth_cfg_port synth_cfg_port_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pl_lvl    (pl_lvl),
    .sclk_rise (sclk_rise),
    .xfer_fall (xfer_fall),
    .sr_q      (sr_q),
    .m_o       (m_o),
    .n_o       (n_o),
    .t_o       (t_o),
    .ser_tap_o (ser_tap_o)
);

// File: tb/tb_synth_cfg_port.sv
module tb_synth_cfg_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pstrobe = 1'b0;
    logic [8:0] par_m = '0;
    logic [1:0] par_n = '0;
    logic       sclk = 1'b0;
    logic       sdat = 1'b0;
    logic       sxfer = 1'b0;
    logic [8:0] m_o;
    logic [1:0] n_o;
    logic [2:0] t_o;
    logic       tap;

    int errors = 0;
    int checks = 0;

    logic [13:0] mdl_sr;
    logic [8:0]  exp_m;
    logic [1:0]  exp_n;
    logic [2:0]  exp_t;

    always #2.5 clk = ~clk;

    synth_cfg_port dut (
        .clk (clk), .rst_n (rst_n), .pstrobe_i (pstrobe),
        .par_m_i (par_m), .par_n_i (par_n),
        .ser_clk_i (sclk), .ser_dat_i (sdat), .ser_xfer_i (sxfer),
        .m_o (m_o), .n_o (n_o), .t_o (t_o), .ser_tap_o (tap)
    );

    function automatic logic [13:0] shift_in(logic [13:0] s, logic b);
        return {s[12:0], b};
    endfunction

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_act(string req);
        chk({req, " m"}, 32'(m_o), 32'(exp_m));
        chk({req, " n"}, 32'(n_o), 32'(exp_n));
        chk({req, " t"}, 32'(t_o), 32'(exp_t));
    endtask

    // Parallel load: transparent while low, then freeze on the rising edge.
    task automatic par_load(logic [8:0] m, logic [1:0] n);
        pstrobe = 1'b0;
        par_m = m; par_n = n;
        wait_cyc(8);
        exp_m = m; exp_n = n; exp_t = 3'b000;
        chk_act("R5/R7 transparent");
        pstrobe = 1'b1;
        wait_cyc(8);
        par_m = 9'($urandom); par_n = 2'($urandom);
        wait_cyc(8);
        chk_act("R6 frozen");
    endtask

    task automatic ser_bit(logic b);
        sdat = b;
        wait_cyc(3);
        sclk = 1'b1;
        wait_cyc(4);
        sclk = 1'b0;
        wait_cyc(3);
        if (pstrobe) mdl_sr = shift_in(mdl_sr, b);
    endtask

    task automatic ser_word(logic [13:0] w);
        for (int i = 13; i >= 0; i--) ser_bit(w[i]);
    endtask

    task automatic ser_xfer();
        sxfer = 1'b1;
        wait_cyc(8);
        chk_act("R4 rising edge no effect");
        sxfer = 1'b0;
        wait_cyc(8);
        if (pstrobe) begin
            exp_t = mdl_sr[13:11]; exp_n = mdl_sr[10:9]; exp_m = mdl_sr[8:0];
        end
    endtask

    initial begin
        logic [13:0] w;
        logic [13:0] keep;
        void'($urandom(32'h5eed));
        mdl_sr = '0; exp_m = '0; exp_n = '0; exp_t = '0;
        pstrobe = 1'b1;
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(1);
        chk_act("R1 reset");
        chk("R1 tap", 32'(tap), 32'd0);

        // Directed: parallel load then a serial word with distinct fields (R3).
        par_load(9'd262, 2'b01);
        w = {3'b101, 2'b10, 9'b1_0000_0011};
        ser_word(w);
        chk("R2 tap after full word", 32'(tap), 32'(w[13]));
        chk("R10 hold before transfer m", 32'(m_o), 32'd262);
        ser_xfer();
        chk("R3 test field", 32'(t_o), 32'b101);
        chk("R3 post-div field", 32'(n_o), 32'b10);
        chk("R3 divide field", 32'(m_o), 32'h103);
        chk_act("R4 transfer");

        // Partial shift: the tap shows the bit entered 13 places earlier (R2).
        ser_word(14'h2AAA);
        for (int k = 0; k < 5; k++) begin
            ser_bit(k[0]);
            chk("R2 tap partial", 32'(tap), 32'(mdl_sr[13]));
        end

        // Directed: serial activity with the parallel strobe low (R8, R9).
        w = 14'($urandom);
        ser_word(w);
        keep = mdl_sr;
        pstrobe = 1'b0;
        par_m = 9'd77; par_n = 2'b11;
        wait_cyc(8);
        exp_m = 9'd77; exp_n = 2'b11; exp_t = 3'b000;
        ser_word(~w);
        chk("R8 tap unchanged", 32'(tap), 32'(keep[13]));
        sxfer = 1'b1; wait_cyc(8); sxfer = 1'b0; wait_cyc(8);
        chk_act("R9 transfer ignored");
        pstrobe = 1'b1;
        wait_cyc(8);
        chk_act("R6 frozen after low phase");
        ser_xfer();
        chk("R8 register kept", 32'({t_o, n_o, m_o}), 32'(keep));

        // Random mix of parallel and serial loads.
        for (int it = 0; it < 24; it++) begin
            if ($urandom_range(3) == 0) par_load(9'($urandom), 2'($urandom));
            w = 14'($urandom);
            ser_word(w);
            chk("R2 tap random", 32'(tap), 32'(w[13]));
            ser_xfer();
            chk({"R3 random word"}, 32'({t_o, n_o, m_o}), 32'(w));
            wait_cyc($urandom_range(5));
            chk_act("R10 hold");
        end

        // Lowering the strobe after a serial load clears the test field (R7).
        pstrobe = 1'b0;
        wait_cyc(8);
        chk("R7 test cleared", 32'(t_o), 32'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog got=timeout exp=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule